// File: doc/BRIEF.md
# 64-bit Integer Execution Unit with Signed Overflow Trap

This block is the integer stage of a 64-bit processor pipeline. It adds and subtracts, applies bitwise AND, OR and XOR, compares with set-less-than, builds upper constants and shifts left or right. Each operation takes two 64-bit register operands, a 16-bit immediate, a 4-bit operation code and an immediate-select flag. When the flag is set, the immediate replaces the second operand. Whether the immediate is extended with its sign bit or with zeros depends on the operation.

The result is registered, so it appears one clock after the request. The signed add and subtract forms check for two's-complement overflow. When they overflow, the block raises a trap flag and holds back its register-file write enable. The unsigned forms wrap silently.

Top module: `alu64_top`

## Requirements
- R1: After a synchronous active-high reset, `out_valid_o`, `wr_en_o` and `trap_o` are 0.
- R2: A request accepted with `in_valid_i` high produces `out_valid_o` high exactly one clock later with its result. With no request, `out_valid_o` is low in the next cycle.
- R3: Operation codes 0 (signed add) and 2 (signed subtract, a minus b) raise `trap_o` on two's-complement overflow. Codes 1 (unsigned add) and 3 (unsigned subtract) never raise it.
- R4: `wr_en_o` is high exactly when `out_valid_o` is high and `trap_o` is low.
- R5: With `imm_sel_i` set, the immediate is sign-extended (bit 15 copied upward) for codes 0, 1, 2, 3, 7 and 8.
- R6: With `imm_sel_i` set, the immediate is zero-extended for codes 4 (AND), 5 (OR) and 6 (XOR).
- R7: Code 7 writes 1 when a is less than the second operand as signed values, and 0 otherwise. Code 8 does the same with an unsigned comparison. All other result bits are 0.
- R8: Code 9 (load upper) writes the immediate into result bits 31..16 (LSB-0 numbering), clears bits 15..0 and copies immediate bit 15 into bits 63..32. Operand a is ignored.
- R9: Codes 10, 11 and 12 shift a left logically, right logically and right arithmetically. The shift amount is immediate bits 5..0 when `imm_sel_i` is set, otherwise b bits 5..0. All higher bits of the amount source are ignored.
- R10: Add and subtract results wrap modulo 2^64, including when a trap is raised.
- R11: Codes 13 to 15 give a zero result with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| imm_sel_i | input | 1 | Use immediate as second operand / shift amount |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| imm_i | input | 16 | Immediate |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |
| trap_o | output | 1 | Signed overflow trap |
| wr_en_o | output | 1 | Result write enable |

## Verification
Every result, trap and write enable is due on the clock edge after the request. The driver places the expected item in a queue on the falling edge where it presents the request. The monitor samples on each later falling edge and pops one item for every cycle in which `out_valid_o` is high, so a result one cycle early or late shows up as an empty queue, a mismatch or leftover items. Back-to-back requests and idle gaps are mixed so that the one-cycle rule is tested both with and without a pipeline bubble.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
    localparam int XLEN  = 64;
    localparam int IMMW  = 16;
    localparam int SHW   = $clog2(XLEN);
    localparam int OPW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLT  = 4'd7,
        OP_SLTU = 4'd8,
        OP_LUI  = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            trap;
    } alu_res_t;

    function automatic logic imm_is_signed(alu_op_e op);
        return op inside {OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_SLT, OP_SLTU};
    endfunction

    function automatic logic op_subtracts(alu_op_e op);
        return op inside {OP_SUB, OP_SUBU, OP_SLT, OP_SLTU};
    endfunction
endpackage

// File: rtl/alu64_opsel.sv
module alu64_opsel
    import alu64_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IMM_W  = IMMW,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] operand,
    output logic [SH_W-1:0]   shamt
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm_is_signed(op) & imm[IMM_W-1]}}, imm};
        operand = imm_sel ? imm_ext : b;
        shamt   = imm_sel ? imm[SH_W-1:0] : b[SH_W-1:0];
    end
endmodule

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf,
    output logic              lt_s,
    output logic              lt_u
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum   = wide[DATA_W-1:0];
        // overflow: operands (after inversion) agree in sign, sum disagrees
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        // unsigned borrow is the missing carry out of a + ~b + 1
        lt_u  = ~wide[DATA_W];
        lt_s  = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
    end
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
    parameter int DATA_W = 64,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   shamt,
    input  logic              right,
    input  logic              arith,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] stage [SH_W+1];
    logic [DATA_W-1:0] a_rev;
    logic              fill;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) a_rev[i] = a[DATA_W-1-i];
        fill = right & arith & a[DATA_W-1];
    end

    assign stage[0] = right ? a_rev : a;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stage[k+1] = shamt[k]
            ? {stage[k][DATA_W-1-DIST:0], {DIST{fill}}}
            : stage[k];
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            y[i] = right ? stage[SH_W][DATA_W-1-i] : stage[SH_W][i];
    end
endmodule

// File: rtl/alu64_top.sv
module alu64_top
    import alu64_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IMM_W  = IMMW,
    parameter int OP_W   = OPW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              imm_sel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              trap_o,
    output logic              wr_en_o
);
    localparam int SH_W    = $clog2(DATA_W);
    localparam int UPPER_W = DATA_W - 2 * IMM_W;

    alu_op_e           op;
    logic [DATA_W-1:0] operand, sum, sh_y;
    logic [SH_W-1:0]   shamt;
    logic              ovf, lt_s, lt_u;
    alu_res_t          nxt, cur;
    logic              vld_q;

    assign op = alu_op_e'(op_i);

    alu64_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_opsel (
        .op(op), .imm_sel(imm_sel_i), .b(b_i), .imm(imm_i),
        .operand(operand), .shamt(shamt)
    );

    alu64_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(a_i), .b(operand), .sub(op_subtracts(op)),
        .sum(sum), .ovf(ovf), .lt_s(lt_s), .lt_u(lt_u)
    );

    alu64_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .a(a_i), .shamt(shamt),
        .right(op inside {OP_SRL, OP_SRA}), .arith(op == OP_SRA),
        .y(sh_y)
    );

    always_comb begin
        nxt = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                nxt.result = sum;
                nxt.trap   = ovf;
            end
            OP_ADDU, OP_SUBU: nxt.result = sum;
            OP_AND:  nxt.result = a_i & operand;
            OP_OR:   nxt.result = a_i | operand;
            OP_XOR:  nxt.result = a_i ^ operand;
            OP_SLT:  nxt.result = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: nxt.result = {{(DATA_W-1){1'b0}}, lt_u};
            OP_LUI:  nxt.result = {{UPPER_W{imm_i[IMM_W-1]}}, imm_i, {IMM_W{1'b0}}};
            OP_SLL, OP_SRL, OP_SRA: nxt.result = sh_y;
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= in_valid_i;
            if (in_valid_i) cur <= nxt;
            else            cur.trap <= 1'b0;
        end
    end

    assign out_valid_o = vld_q;
    assign result_o    = cur.result;
    assign trap_o      = cur.trap;
    assign wr_en_o     = vld_q & ~cur.trap;
endmodule

// File: rtl/alu64_chk.sv
module alu64_chk
    import alu64_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IMM_W  = IMMW,
    parameter int OP_W   = OPW
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic              imm_sel_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              trap_o,
    input logic              wr_en_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid_o && !wr_en_o && !trap_o));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);

    p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && (op_i == 4'd1 || op_i == 4'd3)) |=> !trap_o);

    p_trap_blocks_write_r4: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (out_valid_o && !wr_en_o));

    p_write_when_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !trap_o) |-> wr_en_o);

    p_slt_boolean_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && (op_i == 4'd7 || op_i == 4'd8)) |=> (result_o[DATA_W-1:1] == '0));

    p_lui_low_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && op_i == 4'd9) |=> (result_o[IMM_W-1:0] == '0));

    p_unused_code_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && op_i > 4'd12) |=> (result_o == '0 && !trap_o));
endmodule

bind alu64_top alu64_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OP_W(OP_W)) u_chk (.*);

// File: tb/tb_alu64_top.sv
module tb_alu64_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [15:0] imm_i = '0;
    logic        out_valid_o, trap_o, wr_en_o;
    logic [63:0] result_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [63:0] res;
        logic        trap;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    alu64_top dut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .op_i(op_i),
        .imm_sel_i(imm_sel_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .out_valid_o(out_valid_o), .result_o(result_o),
        .trap_o(trap_o), .wr_en_o(wr_en_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference built from the requirement text
    function automatic exp_t model(input logic [3:0] op, input logic sel,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic [15:0] imm);
        exp_t e;
        logic [63:0] sx, zx, o2, ol;
        logic signed [64:0] w;
        logic [5:0] n;
        sx = 64'($signed(imm));
        zx = {48'd0, imm};
        o2 = sel ? sx : b;
        ol = sel ? zx : b;
        n  = sel ? imm[5:0] : b[5:0];
        e.res = '0; e.trap = 1'b0; e.tag = "R10/model";
        case (op)
            4'd0: begin w = $signed({a[63], a}) + $signed({o2[63], o2});
                        e.res = w[63:0]; e.trap = (w[64] != w[63]); end
            4'd1: e.res = a + o2;
            4'd2: begin w = $signed({a[63], a}) - $signed({o2[63], o2});
                        e.res = w[63:0]; e.trap = (w[64] != w[63]); end
            4'd3: e.res = a - o2;
            4'd4: e.res = a & ol;
            4'd5: e.res = a | ol;
            4'd6: e.res = a ^ ol;
            4'd7: e.res = {63'd0, ($signed(a) < $signed(o2))};
            4'd8: e.res = {63'd0, (a < o2)};
            4'd9: e.res = {{32{imm[15]}}, imm, 16'h0};
            4'd10: e.res = a << n;
            4'd11: e.res = a >> n;
            4'd12: e.res = 64'($signed(a) >>> n);
            default: e.res = '0;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic sel, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] imm,
                         input logic [63:0] eres, input logic etrap, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid_i = 1'b1; op_i = op; imm_sel_i = sel; a_i = a; b_i = b; imm_i = imm;
        e.res = eres; e.trap = etrap; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drive_model(input logic [3:0] op, input logic sel, input logic [63:0] a,
                               input logic [63:0] b, input logic [15:0] imm);
        exp_t e;
        e = model(op, sel, a, b, imm);
        drive(op, sel, a, b, imm, e.res, e.trap, e.tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid_i = 1'b0; a_i = '1; b_i = '1; imm_i = '1; op_i = 4'd0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid_o) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2 unexpected result actual=%h expected=none", result_o);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " result"}, result_o, e.res);
                    check({e.tag, " trap R3"}, {63'd0, trap_o}, {63'd0, e.trap});
                    check({e.tag, " wr_en R4"}, {63'd0, wr_en_o}, {63'd0, ~e.trap});
                end
            end else begin
                check("R4 wr_en idle", {63'd0, wr_en_o}, 64'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid", {63'd0, out_valid_o}, 64'd0);
        check("R1 wr_en", {63'd0, wr_en_o}, 64'd0);
        check("R1 trap", {63'd0, trap_o}, 64'd0);
        rst = 1'b0;

        drive(4'd0, 0, 64'd1, 64'd2, 16'h0, 64'd3, 0, "R10 add");
        drive(4'd0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h8000_0000_0000_0000, 1, "R3 add ovf");
        drive(4'd1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h8000_0000_0000_0000, 0, "R3 addu");
        idle();
        drive(4'd2, 0, 64'h8000_0000_0000_0000, 64'd1, 16'h0, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R3 sub ovf");
        drive(4'd3, 0, 64'd0, 64'd1, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10 subu wrap");
        drive(4'd0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001, 64'h8000_0000_0000_0000, 1, "R3 addi ovf");
        drive(4'd0, 1, 64'd10, 64'd0, 16'hFFFF, 64'd9, 0, "R5 addi sext");
        drive(4'd4, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h8000, 64'h0000_0000_0000_8000, 0, "R6 andi zext");
        drive(4'd5, 1, 64'd0, 64'hFFFF, 16'hFFFF, 64'h0000_0000_0000_FFFF, 0, "R6 ori zext");
        drive(4'd6, 1, 64'hFFFF_0000_0000_0000, 64'd0, 16'hF00F, 64'hFFFF_0000_0000_F00F, 0, "R6 xori zext");
        idle(); idle();
        drive(4'd7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'd1, 0, "R7 slt signed");
        drive(4'd8, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'd0, 0, "R7 sltu unsigned");
        drive(4'd7, 1, 64'd0, 64'd0, 16'hFFFF, 64'd0, 0, "R5 slti sext");
        drive(4'd8, 1, 64'd5, 64'd0, 16'hFFFF, 64'd1, 0, "R5 sltiu sext");
        drive(4'd9, 0, 64'h1234_5678_9ABC_DEF0, 64'd0, 16'h8000, 64'hFFFF_FFFF_8000_0000, 0, "R8 lui neg");
        drive(4'd9, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h1234, 64'h0000_0000_1234_0000, 0, "R8 lui pos");
        drive(4'd10, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FF41, 16'h0, 64'd2, 0, "R9 sllv low bits");
        drive(4'd12, 1, 64'h8000_0000_0000_0000, 64'd0, 16'hFFBF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R9 sra 63");
        drive(4'd11, 1, 64'h8000_0000_0000_0000, 64'd0, 16'h003F, 64'd1, 0, "R9 srl 63");
        drive(4'd12, 0, 64'h8000_0000_0000_0001, 64'h40, 16'h0, 64'h8000_0000_0000_0001, 0, "R9 srav zero");
        drive(4'd15, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'd0, 0, "R11 unused code");
        idle();

        for (int i = 0; i < 300; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            drive_model(op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom));
            if (i % 7 == 0) idle();
        end
        idle(); idle(); idle();

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing results actual=%0d expected=0", q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule